// File: doc/BRIEF.md
# Bus Arbiter with Grant Hold

This block arbitrates ownership of a shared parallel bus among ten requestors, each with its own request line and grant line. Only one requestor owns the bus at a time. Pending requests are served round-robin. When an owner's transaction finishes, the arbiter can keep that owner's grant asserted for a programmed number of clocks. During that window the owner can start another transaction at once, with no need to win arbitration again. A per-requestor mask selects which requestors get this hold window.

A configuration input carries three settings: a 3-bit hold code, the hold mask, and a parking switch. When parking is on and nothing is pending, the grant rests on requestor 0. An illegal hold code turns the hold window off and sets a sticky error flag. Bus signalling, addressing and data movement are handled elsewhere. The arbiter sees only the request lines, a transaction-done pulse from the current owner, and its own grant outputs.

Top module: `grant_hold_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle. All grants are low while reset is asserted and just after it is released.
- R2: When no grant is active, the arbiter scans pending requests round-robin. The scan begins at the index one above the most recent owner and wraps from 9 to 0. Right after reset the scan begins at index 0. The chosen grant is visible on the clock edge that follows the one that saw the request.
- R3: The hold length comes from the hold code. Code 1 gives 16 clocks, 2 gives 32, 3 gives 64, 4 gives 128 and 5 gives 256. Suppose the owner's mask bit is set and the code is legal when `xfer_done_i` is sampled. The owner's grant then stays high for exactly that many more clocks, provided the owner does not request again, and then goes low.
- R4: Hold codes 0, 6 and 7 are illegal. With one of these codes, a finished transaction releases the grant on the next clock. `cfg_err_o` rises one clock after an illegal code is seen, and only a reset clears it.
- R5: A requestor whose bit in `cfg_hold_mask_i` is 0 loses its grant on the clock after its `xfer_done_i` is sampled.
- R6: If the owner raises its request again during the hold window, its grant stays high without a break, and a new transaction begins. The next `xfer_done_i` starts a fresh full-length hold.
- R7: During a hold window, requests from other requestors do not shorten the hold. The owner keeps the grant until the window runs out.
- R8: When ownership passes from one requestor to a different one, there is at least one clock with every grant low in between.
- R9: With `cfg_park_en_i` at 1 and no request pending, an idle arbiter parks the grant on requestor 0 on the next clock. With `cfg_park_en_i` at 0, an idle arbiter drives no grant.
- R10: While parked, a request from requestor 0 turns the parked grant into a real transaction with no gap. A request from any other requestor first drops the parked grant for one clock, and the next clock grants the requestor chosen by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 10 | Request line per requestor |
| xfer_done_i | input | 1 | One-clock pulse: current owner's transaction has finished |
| cfg_hold_code_i | input | 3 | Hold length code (1..5 legal) |
| cfg_hold_mask_i | input | 10 | Per-requestor hold enable |
| cfg_park_en_i | input | 1 | Park the grant on requestor 0 when idle |
| gnt_o | output | 10 | One-hot-or-zero grant per requestor |
| cfg_err_o | output | 1 | Sticky flag: an illegal hold code was seen |

## Verification
Every result here comes out of a register, so each one appears on the rising edge after the edge that sampled its cause. A new grant shows one clock after the request. A release without hold shows one clock after the done pulse. A hold lasts exactly the coded count of clocks after the done pulse. The error flag rises one clock after an illegal code. The bench drives inputs on the falling edge and reads outputs on the next falling edge, and it keeps a cycle-level behavioural model that updates on the same rising edge as the design. Directed sequences count held clocks and check the one-clock gaps edge by edge. A seeded random phase then compares grants and the error flag against the model on every cycle.

// File: rtl/gha_pkg.sv
package gha_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2,
    ST_PARK = 2'd3
  } arb_state_e;

  // Hold code c (legal range MIN..MAX) selects 2^(c + SHIFT_OFS) clocks.
  localparam int unsigned HOLD_CODE_W    = 3;
  localparam int unsigned HOLD_CODE_MIN  = 1;
  localparam int unsigned HOLD_CODE_MAX  = 5;
  localparam int unsigned HOLD_SHIFT_OFS = 3;
  localparam int unsigned HOLD_CNT_W     = HOLD_CODE_MAX + HOLD_SHIFT_OFS + 1;

endpackage

// File: rtl/gha_rst_sync.sv
module gha_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gha_cfg_decode.sv
module gha_cfg_decode #(
  parameter int unsigned CODE_W    = gha_pkg::HOLD_CODE_W,
  parameter int unsigned CNT_W     = gha_pkg::HOLD_CNT_W,
  parameter int unsigned CODE_MIN  = gha_pkg::HOLD_CODE_MIN,
  parameter int unsigned CODE_MAX  = gha_pkg::HOLD_CODE_MAX,
  parameter int unsigned SHIFT_OFS = gha_pkg::HOLD_SHIFT_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              err_o
);

  logic err_q;
  logic err_en;

  always_comb begin
    legal_o = (32'(code_i) >= CODE_MIN) && (32'(code_i) <= CODE_MAX);
    len_o   = legal_o ? (CNT_W'(1) << (32'(code_i) + SHIFT_OFS)) : '0;
    err_en  = !legal_o && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  // R4: flag stays set once raised
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R4: an illegal code raises the flag on the next clock
  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_o |=> err_q);

endmodule

// File: rtl/gha_hold_timer.sv
module gha_hold_timer #(
  parameter int unsigned CNT_W = gha_pkg::HOLD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R3: a load takes the full coded length
  p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R3: each running clock takes exactly one count off
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/gha_rr_pick.sv
module gha_rr_pick #(
  parameter int unsigned NUM_REQ = 10,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [IDX_W-1:0]   last_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   pick_o
);

  always_comb begin
    int unsigned idx;
    any_o  = 1'b0;
    pick_o = '0;
    for (int unsigned k = 0; k < NUM_REQ; k++) begin
      idx = 32'(last_i) + 1 + k;
      if (idx >= NUM_REQ) begin
        idx = idx - NUM_REQ;
      end
      if (!any_o && req_i[idx]) begin
        any_o  = 1'b1;
        pick_o = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/grant_hold_arbiter.sv
module grant_hold_arbiter
  import gha_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 10,
  parameter int unsigned PARK_IDX   = 0,
  parameter int unsigned CODE_W     = HOLD_CODE_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               xfer_done_i,
  input  logic [CODE_W-1:0]  cfg_hold_code_i,
  input  logic [NUM_REQ-1:0] cfg_hold_mask_i,
  input  logic               cfg_park_en_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               cfg_err_o
);

  localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int unsigned CNT_W = HOLD_CNT_W;
  localparam logic [IDX_W-1:0] PARK_ID  = IDX_W'(PARK_IDX);
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM_REQ - 1);

  logic rst_sync_n;

  arb_state_e         state_q, state_d;
  logic [IDX_W-1:0]   owner_q, owner_d;
  logic [IDX_W-1:0]   last_q, last_d;
  logic [NUM_REQ-1:0] gnt_q, gnt_d;
  logic               sel_en;

  logic               rr_any;
  logic [IDX_W-1:0]   rr_pick;
  logic               code_legal;
  logic [CNT_W-1:0]   hold_len;
  logic               tmr_load, tmr_run, tmr_expire;
  logic               hold_ok, owner_req, grant_on_d;

  gha_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gha_cfg_decode #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .CODE_MIN  (HOLD_CODE_MIN),
    .CODE_MAX  (HOLD_CODE_MAX),
    .SHIFT_OFS (HOLD_SHIFT_OFS)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_i  (cfg_hold_code_i),
    .legal_o (code_legal),
    .len_o   (hold_len),
    .err_o   (cfg_err_o)
  );

  gha_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_rr (
    .req_i  (req_i),
    .last_i (last_q),
    .any_o  (rr_any),
    .pick_o (rr_pick)
  );

  gha_hold_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (hold_len),
    .run_i      (tmr_run),
    .expire_o   (tmr_expire)
  );

  assign owner_req = req_i[owner_q];
  assign hold_ok   = cfg_hold_mask_i[owner_q] && code_legal;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    owner_d  = owner_q;
    last_d   = last_q;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rr_any) begin
          state_d = ST_BUSY;
          owner_d = rr_pick;
          last_d  = rr_pick;
        end else if (cfg_park_en_i) begin
          state_d = ST_PARK;
          owner_d = PARK_ID;
        end
      end
      ST_BUSY: begin
        if (xfer_done_i) begin
          if (hold_ok) begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (owner_req) begin
          state_d = ST_BUSY;
        end else if (tmr_expire) begin
          state_d = ST_IDLE;
        end else begin
          tmr_run = 1'b1;
        end
      end
      ST_PARK: begin
        if (req_i[PARK_IDX]) begin
          state_d = ST_BUSY;
          last_d  = PARK_ID;
        end else if (rr_any || !cfg_park_en_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign grant_on_d = (state_d != ST_IDLE);
  assign sel_en     = (state_q == ST_IDLE) || (state_q == ST_PARK);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_gnt
    assign gnt_d[g] = grant_on_d && (owner_d == IDX_W'(g));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      owner_q <= '0;
      last_q  <= LAST_RST;
    end else if (sel_en) begin
      owner_q <= owner_d;
      last_q  <= last_d;
    end
  end

  assign gnt_o = gnt_q;

  // R1: never more than one grant
  p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(gnt_q));

  // R1: no grant while reset is held
  always @(posedge clk) begin
    if (rst_sync_n == 1'b0) begin
      a_rst_gnt_r1: assert (gnt_q == '0);
    end
  end

  // R2: the scan only ever returns a requesting index
  p_pick_valid_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rr_any |-> req_i[rr_pick]);

  // R5: a finished transaction without hold releases the bus next clock
  p_nohold_release_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_BUSY) && xfer_done_i && !hold_ok) |=> (gnt_q == '0));

  // R7: a running hold window keeps the grant where it is
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_HOLD) && !tmr_expire) |=> $stable(gnt_q));

  // R8: a grant either stays or drops, never jumps to another requestor
  p_no_direct_switch_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_q != '0) |=> ((gnt_q == '0) || $stable(gnt_q)));

  // R9: idle with parking on and nothing pending parks on the default index
  p_park_on_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_IDLE) && !rr_any && cfg_park_en_i) |=> gnt_q[PARK_IDX]);

  // R9: idle with parking off drives no grant
  p_park_off_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_IDLE) && !rr_any && !cfg_park_en_i) |=> (gnt_q == '0));

  // R10: the parked requestor takes the bus without a gap
  p_park_take_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_PARK) && req_i[PARK_IDX]) |=> $stable(gnt_q));

endmodule

// File: tb/tb_grant_hold_arbiter.sv
`timescale 1ns/1ps
module tb_grant_hold_arbiter;

  localparam int N = 10;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic         xfer_done;
  logic [2:0]   code;
  logic [N-1:0] mask;
  logic         park;
  logic [N-1:0] gnt;
  logic         err;

  int n_checks = 0;
  int n_err    = 0;
  bit mdl_on   = 0;

  grant_hold_arbiter dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req),
    .xfer_done_i     (xfer_done),
    .cfg_hold_code_i (code),
    .cfg_hold_mask_i (mask),
    .cfg_park_en_i   (park),
    .gnt_o           (gnt),
    .cfg_err_o       (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int rr_ref(logic [N-1:0] r, int last);
    for (int k = 1; k <= N; k++) begin
      int i;
      i = (last + k) % N;
      if (r[i]) return i;
    end
    return -1;
  endfunction

  function automatic int hold_ref(logic [2:0] c);
    case (c)
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 64;
      3'd4: return 128;
      3'd5: return 256;
      default: return 0;
    endcase
  endfunction

  // Behavioural model: 0 idle, 1 busy, 2 hold, 3 parked
  int   m_st, m_own, m_last, m_tmr;
  logic m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_own <= 0; m_last <= N - 1; m_tmr <= 0; m_err <= 1'b0;
    end else begin
      if (hold_ref(code) == 0) m_err <= 1'b1;
      case (m_st)
        0: begin
          int p;
          p = rr_ref(req, m_last);
          if (p >= 0) begin m_st <= 1; m_own <= p; m_last <= p; end
          else if (park) begin m_st <= 3; m_own <= 0; end
        end
        1: if (xfer_done) begin
          if (mask[m_own] && hold_ref(code) != 0) begin m_st <= 2; m_tmr <= hold_ref(code); end
          else m_st <= 0;
        end
        2: begin
          if (req[m_own]) m_st <= 1;
          else if (m_tmr == 1) m_st <= 0;
          else m_tmr <= m_tmr - 1;
        end
        default: begin
          if (req[0]) begin m_st <= 1; m_last <= 0; end
          else if (req != '0 || !park) m_st <= 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      logic [N-1:0] e;
      e = (m_st != 0) ? (N'(1) << m_own) : '0;
      chk(gnt == e, "R2 R3 R6 R7 model grant", int'(gnt), int'(e));
      chk(err == m_err, "R4 model error flag", int'(err), int'(m_err));
    end
  end

  task automatic meas_hold(input int who, output int n, output logic [N-1:0] after);
    n = 0;
    after = '0;
    for (int i = 0; i < 400; i++) begin
      cyc();
      xfer_done = 1'b0;
      if (gnt == (N'(1) << who)) n++;
      else begin
        after = gnt;
        break;
      end
    end
  endtask

  initial begin
    int n;
    logic [N-1:0] aft;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = '0; xfer_done = 1'b0; code = 3'd1; mask = '1; park = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(gnt == '0, "R1 reset grant", int'(gnt), 0);
    chk(err == 1'b0, "R1 reset error flag", int'(err), 0);
    mdl_on = 1;

    // R2 round-robin order, no hold (mask clear)
    mask = '0;
    req = N'(10'b0000100100);
    cyc(); chk(gnt == N'(1 << 2), "R2 first pick from index 0", int'(gnt), 1 << 2);
    xfer_done = 1'b1;
    cyc(); xfer_done = 1'b0;
    chk(gnt == '0, "R5 release without hold", int'(gnt), 0);
    cyc(); chk(gnt == N'(1 << 5), "R2 scan after last owner", int'(gnt), 1 << 5);
    xfer_done = 1'b1; req = N'(1 << 2);
    cyc(); xfer_done = 1'b0;
    cyc(); chk(gnt == N'(1 << 2), "R2 wrap around", int'(gnt), 1 << 2);
    xfer_done = 1'b1; req = '0;
    cyc(); xfer_done = 1'b0;
    chk(gnt == '0, "R8 bus idle after release", int'(gnt), 0);

    // R3 hold lengths
    mask = '1;
    for (int ci = 0; ci < 3; ci++) begin
      logic [2:0] c;
      c = (ci == 0) ? 3'd1 : (ci == 1) ? 3'd3 : 3'd5;
      code = c;
      req = N'(1 << 3);
      cyc(); chk(gnt == N'(1 << 3), "R3 grant before hold", int'(gnt), 1 << 3);
      req = '0; xfer_done = 1'b1;
      meas_hold(3, n, aft);
      chk(n == hold_ref(c), "R3 hold length", n, hold_ref(c));
      chk(aft == '0, "R3 grant low after hold", int'(aft), 0);
    end

    // R6 owner re-request during hold
    code = 3'd1;
    req = N'(1 << 4);
    cyc(); chk(gnt == N'(1 << 4), "R6 initial grant", int'(gnt), 1 << 4);
    req = '0; xfer_done = 1'b1;
    cyc(); xfer_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(gnt == N'(1 << 4), "R6 held grant", int'(gnt), 1 << 4);
      cyc();
    end
    req = N'(1 << 4);
    cyc(); chk(gnt == N'(1 << 4), "R6 grant unbroken on re-request", int'(gnt), 1 << 4);
    cyc(); chk(gnt == N'(1 << 4), "R6 new transaction running", int'(gnt), 1 << 4);
    req = '0; xfer_done = 1'b1;
    meas_hold(4, n, aft);
    chk(n == 16, "R6 fresh hold after second transaction", n, 16);

    // R7 / R8 no preemption, gap before handover
    req = N'(1 << 1);
    cyc(); chk(gnt == N'(1 << 1), "R7 owner granted", int'(gnt), 1 << 1);
    req = N'(1 << 7); xfer_done = 1'b1;
    meas_hold(1, n, aft);
    chk(n == 16, "R7 other request does not cut hold", n, 16);
    chk(aft == '0, "R8 idle clock between owners", int'(aft), 0);
    cyc(); chk(gnt == N'(1 << 7), "R8 next owner after gap", int'(gnt), 1 << 7);
    req = '0; xfer_done = 1'b1;
    meas_hold(7, n, aft);

    // R4 illegal codes
    code = 3'd6;
    cyc(); chk(err == 1'b1, "R4 error flag raised", int'(err), 1);
    for (int ci = 0; ci < 3; ci++) begin
      code = (ci == 0) ? 3'd6 : (ci == 1) ? 3'd0 : 3'd7;
      req = N'(1 << 8);
      cyc(); chk(gnt == N'(1 << 8), "R4 grant with illegal code", int'(gnt), 1 << 8);
      req = '0; xfer_done = 1'b1;
      cyc(); xfer_done = 1'b0;
      chk(gnt == '0, "R4 illegal code gives no hold", int'(gnt), 0);
    end
    code = 3'd1;
    cyc(); chk(err == 1'b1, "R4 error flag sticky", int'(err), 1);

    // R5 mask bit clear
    mask = ~N'(1 << 6);
    req = N'(1 << 6);
    cyc(); chk(gnt == N'(1 << 6), "R5 grant", int'(gnt), 1 << 6);
    req = '0; xfer_done = 1'b1;
    cyc(); xfer_done = 1'b0;
    chk(gnt == '0, "R5 masked requestor released", int'(gnt), 0);

    // R9 parking
    park = 1'b1;
    cyc(); chk(gnt == N'(1), "R9 parked on requestor 0", int'(gnt), 1);
    park = 1'b0;
    cyc(); chk(gnt == '0, "R9 parking off drops grant", int'(gnt), 0);

    // R10 leaving the park
    park = 1'b1; mask = '0;
    cyc(); chk(gnt == N'(1), "R10 parked", int'(gnt), 1);
    req = N'(1 << 4);
    cyc(); chk(gnt == '0, "R10 gap before other requestor", int'(gnt), 0);
    cyc(); chk(gnt == N'(1 << 4), "R10 other requestor granted", int'(gnt), 1 << 4);
    req = '0; xfer_done = 1'b1;
    cyc(); xfer_done = 1'b0;
    chk(gnt == '0, "R10 release", int'(gnt), 0);
    cyc(); chk(gnt == N'(1), "R9 re-parked", int'(gnt), 1);
    req = N'(1);
    cyc(); chk(gnt == N'(1), "R10 parked requestor takes bus", int'(gnt), 1);
    cyc(); chk(gnt == N'(1), "R10 no gap", int'(gnt), 1);
    req = '0; xfer_done = 1'b1; park = 1'b0;
    cyc(); xfer_done = 1'b0;
    chk(gnt == '0, "R10 parked owner released", int'(gnt), 0);

    // Random phase against the model
    for (int t = 0; t < 4000; t++) begin
      if (t % 200 == 0) begin
        code = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(1 + $urandom % 2);
        mask = N'($urandom);
        park = 1'($urandom % 2);
      end
      for (int b = 0; b < N; b++) req[b] = ($urandom % 100) < 20;
      xfer_done = ($urandom % 100) < 30;
      cyc();
    end

    mdl_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule